// File: doc/BRIEF.md
# Buffered Compare/Capture Timer Channel

This block is one 16-bit timer channel. An up-counter advances on a clock-enable pulse while a run bit is set. Four general registers (A, B, C, D) each work as either an output-compare register or an input-capture register. Two output pins are driven by compare events, and two input pins feed capture events. Pin 0 is served by A (primary) and C (secondary). Pin 1 is served by B and D.

Either pair can be chained. In that case C (or D) acts as a buffer for A (or B) instead of working on its own. In compare mode the buffer reloads the primary register on each match. In capture mode the buffer receives the primary register's previous value.

Software reaches the channel through a small word-addressed register bus with byte enables. The counter and the four general registers refuse partial-width accesses and report them on an error output.

Register map (word index): 0 control, 1 pairing mode, 2 pin/function control, 3 counter, 4 to 7 general registers A to D.

Top module: `tmr_chan`

## Requirements
- R1: After synchronous reset, every register reads 0x0000, both output pins are 0 and the error output is 0. A one-cycle `standby` pulse clears the counter to 0x0000.
- R2: The counter increments by one on each cycle with both the run bit (control bit 0) and `tick` set. Otherwise it holds. A full-word write to index 3 loads it directly.
- R3: Any access to index 3 to 7 whose byte enables are not both set raises `bus_err` in the following cycle. A write of this kind leaves the target unchanged. A read of this kind returns 0. Full-word accesses leave `bus_err` low.
- R4: Each register has a 4-bit field in the pin/function control word: A in bits 3:0, B in 7:4, C in 11:8, D in 15:12. Field bit 3 = 0 selects compare. Bits 1:0 give the action: 00 none, 01 drive 0, 10 drive 1, 11 toggle. On a tick where the counter equals a compare register, the pin takes that action, and the result is visible after that clock edge.
- R5: While the run bit is 0, the output pins keep their last level, whatever `tick` does.
- R6: A write to the pin/function control word while the run bit is 0 drives each pin, at the next edge, to bit 2 of its primary field (A for pin 0, B for pin 1). The same write while running leaves the pins alone.
- R7: The pairing-mode word (bit 0 chains C into A, bit 1 chains D into B) accepts writes only while the run bit is 0. Writes while running are ignored.
- R8: With field bit 3 = 1 the register captures. Bit 0 = 0 selects the rising edge and bit 0 = 1 the falling edge of its pin input. The input passes through a 2-flop synchronizer. A change applied before clock edge E0 loads the counter value into the register at edge E2. The opposite edge is ignored.
- R9: When A/B is chained and in compare mode, each match copies C/D into A/B at the same edge as the pin action.
- R10: When A/B is chained and in capture mode, a capture moves the old A/B value into C/D.
- R11: When not chained, C/D compares act on the pin of the same pair. On a simultaneous match the A/B action wins.
- R12: A count step from 0xFFFF gives 0x0000 and sets the overflow flag (control bit 8). Writing control with bit 8 = 1 and the high byte enabled clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Clears the counter while high |
| tick | input | 1 | Count enable pulse |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_be | input | 2 | Byte enables (bit 1 = high byte) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| bus_err | output | 1 | Partial-width access error, one cycle after the access |
| cap_in | input | 2 | Capture inputs for pins 0 and 1 |
| cmp_out | output | 2 | Compare outputs for pins 0 and 1 |

## Verification
A wrong counter or register value shows on the compare pins at the tick where the match should occur, one edge later. It also shows on a word read in the same cycle. A broken synchronizer or edge choice shifts a captured value by a cycle, or skips it. This is seen three edges after the pin change, so the bench holds the counter still and reads at exact negedges. Errors in buffer chaining, pin priority and the stop/initial-level rules show at the pin or in the paired register within one edge of the event that triggers them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NUM_PINS = 2;
    localparam int NUM_GR   = 2 * NUM_PINS;
    localparam int GR_BASE  = 4;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_MODE  = 3'd1;
    localparam logic [2:0] A_IOC   = 3'd2;
    localparam logic [2:0] A_COUNT = 3'd3;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } pin_act_e;

    // One nibble per general register in the pin/function control word.
    typedef struct packed {
        logic       capture;   // 1: input capture, 0: output compare
        logic       init_lvl;  // level forced on load while stopped
        logic [1:0] code;      // compare action, or bit0 = falling edge
    } ioc_field_t;

    function automatic logic apply_act(pin_act_e act, logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         standby,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TOP = '1;

    logic step;
    assign step = run && tick;
    assign wrap = step && !load && !standby && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || standby) cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (step)      cnt <= cnt + ONE;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !standby) |=> (cnt == $past(cnt) + ONE));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!step && !load && !standby) |=> $stable(cnt));
    p_standby_r1: assert property (@(posedge clk) disable iff (rst)
        standby |=> (cnt == '0));
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] && !prev_q;
    assign fall = !sync_q[STAGES-1] && prev_q;

    p_rise_once_r8: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_init,
    input  logic     init_lvl,
    input  logic     hit_pri,
    input  pin_act_e act_pri,
    input  logic     hit_sec,
    input  pin_act_e act_sec,
    output logic     pin
);
    always_ff @(posedge clk) begin
        if (rst)            pin <= 1'b0;
        else if (load_init) pin <= init_lvl;
        else if (hit_pri)   pin <= apply_act(act_pri, pin);
        else if (hit_sec)   pin <= apply_act(act_sec, pin);
    end

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_init && !hit_pri && !hit_sec) |=> $stable(pin));
    p_init_load_r6: assert property (@(posedge clk) disable iff (rst)
        load_init |=> (pin == $past(init_lvl)));
    p_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        (hit_pri && !load_init && act_pri == ACT_TOGGLE) |=> (pin != $past(pin)));
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int W           = 16,  // bus and counter width; control layout needs 16
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                standby,
    input  logic                tick,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [2:0]          bus_addr,
    input  logic [1:0]          bus_be,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata,
    output logic                bus_err,
    input  logic [NUM_PINS-1:0] cap_in,
    output logic [NUM_PINS-1:0] cmp_out
);
    localparam int HB = W / 2;

    logic                wr, full, bad;
    logic [W-1:0]        wmask;
    logic                run_q, ovf_q, err_q;
    logic [NUM_PINS-1:0] mode_q;
    ioc_field_t [NUM_GR-1:0] ioc_q, ioc_next;
    logic [W-1:0]        cnt;
    logic                wrap;
    logic [W-1:0]        gr_q [NUM_GR];
    logic [NUM_GR-1:0]   cnt_hit, cap_hit, gr_wsel;
    logic [NUM_PINS-1:0] rise, fall, ioc_load;

    assign wr    = bus_en && bus_we;
    assign full  = (bus_be == 2'b11);
    assign bad   = bus_en && (bus_addr >= A_COUNT) && !full;
    assign wmask = {{(W-HB){bus_be[1]}}, {HB{bus_be[0]}}};
    assign ioc_next = (ioc_q & ~wmask) | (bus_wdata & wmask);
    assign bus_err  = err_q;

    tmr_counter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .standby  (standby),
        .run      (run_q),
        .tick     (tick),
        .load     (wr && full && bus_addr == A_COUNT),
        .load_val (bus_wdata),
        .cnt      (cnt),
        .wrap     (wrap)
    );

    for (genvar k = 0; k < NUM_GR; k++) begin : g_evt
        localparam int PIN = k % NUM_PINS;
        assign cnt_hit[k] = run_q && tick && !ioc_q[k].capture && (cnt == gr_q[k]);
        assign cap_hit[k] = ioc_q[k].capture && (ioc_q[k].code[0] ? fall[PIN] : rise[PIN]);
        assign gr_wsel[k] = wr && full && (bus_addr == 3'(GR_BASE + k));
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (cap_in[p]),
            .rise (rise[p]),
            .fall (fall[p])
        );
        assign ioc_load[p] = wr && (bus_addr == A_IOC) && !run_q;
        tmr_pin_ctl u_pin (
            .clk       (clk),
            .rst       (rst),
            .load_init (ioc_load[p]),
            .init_lvl  (ioc_next[p].init_lvl),
            .hit_pri   (cnt_hit[p]),
            .act_pri   (pin_act_e'(ioc_q[p].code)),
            .hit_sec   (cnt_hit[p+NUM_PINS] && !mode_q[p]),
            .act_sec   (pin_act_e'(ioc_q[p+NUM_PINS].code)),
            .pin       (cmp_out[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            ovf_q  <= 1'b0;
            err_q  <= 1'b0;
            mode_q <= '0;
            ioc_q  <= '0;
        end else begin
            err_q <= bad;
            if (wr && bus_addr == A_CTRL && bus_be[0]) run_q <= bus_wdata[0];
            if (wrap) ovf_q <= 1'b1;
            else if (wr && bus_addr == A_CTRL && bus_be[1] && bus_wdata[8]) ovf_q <= 1'b0;
            if (wr && bus_addr == A_MODE && !run_q && bus_be[0]) mode_q <= bus_wdata[NUM_PINS-1:0];
            if (wr && bus_addr == A_IOC) ioc_q <= ioc_next;
        end
    end

    // Bus writes take priority over hardware updates of the same register.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NUM_GR; k++) gr_q[k] <= '0;
        end else begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (gr_wsel[p])                   gr_q[p] <= bus_wdata;
                else if (cap_hit[p])              gr_q[p] <= cnt;
                else if (cnt_hit[p] && mode_q[p]) gr_q[p] <= gr_q[p+NUM_PINS];

                if (gr_wsel[p+NUM_PINS]) begin
                    gr_q[p+NUM_PINS] <= bus_wdata;
                end else if (mode_q[p]) begin
                    if (cap_hit[p]) gr_q[p+NUM_PINS] <= gr_q[p];
                end else if (cap_hit[p+NUM_PINS]) begin
                    gr_q[p+NUM_PINS] <= cnt;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bad) begin
            case (bus_addr)
                A_CTRL: begin
                    bus_rdata[0] = run_q;
                    bus_rdata[8] = ovf_q;
                end
                A_MODE:  bus_rdata[NUM_PINS-1:0] = mode_q;
                A_IOC:   bus_rdata = ioc_q;
                A_COUNT: bus_rdata = cnt;
                default: bus_rdata = gr_q[bus_addr[1:0]];
            endcase
        end
    end

    p_byte_err_r3: assert property (@(posedge clk) disable iff (rst)
        bad |=> bus_err);
    p_byte_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (bad && bus_we && bus_addr == A_COUNT && !run_q && !standby) |=> $stable(cnt));
    p_mode_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == A_MODE && run_q) |=> $stable(mode_q));
    p_ovf_set_r12: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_q);
    p_buf_cmp_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_hit[0] && mode_q[0] && !gr_wsel[0]) |=> (gr_q[0] == $past(gr_q[2])));
    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_hit[0] && !gr_wsel[0]) |=> (gr_q[0] == $past(cnt)));
    p_buf_cap_r10: assert property (@(posedge clk) disable iff (rst)
        (cap_hit[0] && mode_q[0] && !gr_wsel[2]) |=> (gr_q[2] == $past(gr_q[0])));
endmodule

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
    localparam logic [2:0] R_CTRL = 3'd0, R_MODE = 3'd1, R_IOC = 3'd2, R_CNT = 3'd3, R_GR = 3'd4;

    logic        clk = 1'b0, rst = 1'b1, standby = 1'b0, tick = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        bus_err;
    logic [1:0]  cap_in = '0, cmp_out;

    int n_tests = 0, n_fail = 0;
    logic last_err;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    tmr_chan dut (
        .clk(clk), .rst(rst), .standby(standby), .tick(tick),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .cap_in(cap_in), .cmp_out(cmp_out)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        last_err = bus_err;
        bus_en = 1'b0; bus_we = 1'b0; bus_be = 2'b11;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d, input logic [1:0] be = 2'b11);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        @(negedge clk);
        last_err = bus_err;
        bus_en = 1'b0; bus_be = 2'b11;
    endtask

    task automatic tick_once();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    function automatic logic exp_act(input logic [1:0] code, input logic cur);
        case (code)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] exp_cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 pins", {14'b0, cmp_out}, 16'h0);
        check("R1 err", {15'b0, bus_err}, 16'h0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg", d, 16'h0);
        end
        wr(R_CNT, 16'h0077);
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0;
        rd(R_CNT, d);
        check("R1 standby", d, 16'h0);

        // R4, R5, R6, R2: compare sweep over pins, actions and initial levels
        for (int p = 0; p < 2; p++) begin
            for (int act = 0; act < 4; act++) begin
                for (int ini = 0; ini < 2; ini++) begin
                    logic exp_pin;
                    wr(R_CTRL, 16'h0000);
                    wr(R_IOC, 16'({1'b0, 1'(ini), 2'(act)}) << (4 * p));
                    check("R6 init level", {15'b0, cmp_out[p]}, 16'(ini));
                    wr(3'(R_GR + p), 16'd5);
                    wr(R_CNT, 16'd3);
                    wr(R_CTRL, 16'h0001);
                    tick_once(); tick_once();
                    check("R4 before match", {15'b0, cmp_out[p]}, 16'(ini));
                    tick_once();
                    exp_pin = exp_act(2'(act), 1'(ini));
                    check("R4 action", {15'b0, cmp_out[p]}, {15'b0, exp_pin});
                    wr(R_CTRL, 16'h0000);
                    repeat (4) tick_once();
                    check("R5 hold", {15'b0, cmp_out[p]}, {15'b0, exp_pin});
                    rd(R_CNT, d);
                    check("R2 count after stop", d, 16'd6);
                end
            end
        end

        // R6: control write while running leaves pins
        wr(R_CTRL, 16'h0000);
        wr(R_IOC, 16'h0000);
        wr(R_CTRL, 16'h0001);
        wr(R_IOC, 16'h0044);
        check("R6 running write", {14'b0, cmp_out}, 16'h0);
        wr(R_CTRL, 16'h0000);
        wr(R_IOC, 16'h0000);

        // R2: counting with an irregular tick pattern
        wr(R_CNT, 16'h0000);
        wr(R_CTRL, 16'h0001);
        exp_cnt = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            tick = (i % 3 != 1);
            if (i % 3 != 1) exp_cnt++;
        end
        @(negedge clk); tick = 1'b0;
        rd(R_CNT, d);
        check("R2 tick pattern", d, exp_cnt);
        wr(R_CTRL, 16'h0000);

        // R12: wrap and overflow clear
        wr(R_CNT, 16'hFFFE);
        wr(R_CTRL, 16'h0001);
        tick_once(); tick_once();
        rd(R_CNT, d);
        check("R12 wrap value", d, 16'h0000);
        rd(R_CTRL, d);
        check("R12 overflow set", d, 16'h0101);
        wr(R_CTRL, 16'h0100);
        rd(R_CTRL, d);
        check("R12 overflow clear", d, 16'h0000);

        // R7: pairing mode locked while running
        wr(R_CTRL, 16'h0001);
        wr(R_MODE, 16'h0003);
        rd(R_MODE, d);
        check("R7 ignored while running", d, 16'h0000);
        wr(R_CTRL, 16'h0000);
        wr(R_MODE, 16'h0002);
        rd(R_MODE, d);
        check("R7 accepted while stopped", d, 16'h0002);
        wr(R_MODE, 16'h0000);

        // R3: partial-width access
        wr(R_CNT, 16'h0042);
        check("R3 full write no err", {15'b0, last_err}, 16'h0);
        wr(R_CNT, 16'h1234, 2'b01);
        check("R3 byte write err", {15'b0, last_err}, 16'h1);
        rd(R_CNT, d);
        check("R3 count kept", d, 16'h0042);
        wr(3'(R_GR + 1), 16'h5555);
        wr(3'(R_GR + 1), 16'h0000, 2'b10);
        check("R3 byte gr err", {15'b0, last_err}, 16'h1);
        rd(3'(R_GR + 1), d);
        check("R3 gr kept", d, 16'h5555);
        rd(R_CNT, d, 2'b01);
        check("R3 byte read err", {15'b0, last_err}, 16'h1);
        check("R3 byte read data", d, 16'h0000);

        // R8: capture sweep over pins and polarities
        for (int p = 0; p < 2; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [15:0] cval;
                cval = 16'h1000 + 16'(16 * p + pol);
                wr(R_IOC, 16'(8 + pol) << (4 * p));
                @(negedge clk); cap_in[p] = 1'(pol);
                repeat (4) @(negedge clk);
                wr(3'(R_GR + p), 16'hAAAA);
                wr(R_CNT, cval);
                @(negedge clk);
                bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'(R_GR + p); bus_be = 2'b11;
                cap_in[p] = ~1'(pol);
                @(negedge clk);
                check("R8 not yet (1)", bus_rdata, 16'hAAAA);
                @(negedge clk);
                check("R8 not yet (2)", bus_rdata, 16'hAAAA);
                @(negedge clk);
                check("R8 captured", bus_rdata, cval);
                bus_en = 1'b0;
                wr(R_CNT, 16'h7777);
                @(negedge clk); cap_in[p] = 1'(pol);
                repeat (4) @(negedge clk);
                rd(3'(R_GR + p), d);
                check("R8 opposite edge ignored", d, cval);
            end
        end
        @(negedge clk); cap_in = 2'b00;
        repeat (4) @(negedge clk);

        // R10: chained capture
        wr(R_MODE, 16'h0001);
        wr(R_IOC, 16'h0008);
        wr(R_GR, 16'h1111);
        wr(3'(R_GR + 2), 16'h2222);
        wr(R_CNT, 16'h3333);
        @(negedge clk); cap_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        rd(R_GR, d);
        check("R10 primary captured", d, 16'h3333);
        rd(3'(R_GR + 2), d);
        check("R10 old value in buffer", d, 16'h1111);
        @(negedge clk); cap_in[0] = 1'b0;
        repeat (4) @(negedge clk);

        // R9: chained compare with toggle, C field set to drive high (must be unused)
        wr(R_IOC, 16'h0203);
        wr(R_GR, 16'd5);
        wr(3'(R_GR + 2), 16'd9);
        wr(R_CNT, 16'd4);
        wr(R_CTRL, 16'h0001);
        tick_once();
        check("R9 before match", {15'b0, cmp_out[0]}, 16'h0);
        tick_once();
        check("R9 first toggle", {15'b0, cmp_out[0]}, 16'h1);
        rd(R_GR, d);
        check("R9 reload from buffer", d, 16'd9);
        repeat (3) tick_once();
        check("R9 no action between", {15'b0, cmp_out[0]}, 16'h1);
        tick_once();
        check("R9 second toggle", {15'b0, cmp_out[0]}, 16'h0);
        wr(R_CTRL, 16'h0000);

        // R11: unchained C shares pin 0 with lower priority
        wr(R_MODE, 16'h0000);
        wr(R_IOC, 16'h0102);
        wr(R_GR, 16'd7);
        wr(3'(R_GR + 2), 16'd7);
        wr(R_CNT, 16'd6);
        wr(R_CTRL, 16'h0001);
        tick_once(); tick_once();
        check("R11 primary wins", {15'b0, cmp_out[0]}, 16'h1);
        wr(3'(R_GR + 2), 16'd9);
        tick_once();
        check("R11 no match at 8", {15'b0, cmp_out[0]}, 16'h1);
        tick_once();
        check("R11 secondary acts", {15'b0, cmp_out[0]}, 16'h0);
        wr(R_CTRL, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule